// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block sits beside a processor's fetch logic and decides, when asked, whether a pending interrupt may be taken. If it may, the block performs the whole state change on a single clock edge. It owns the program counter, the processor status word, and the vector-base register. It also owns a bank of saved-PC and saved-status registers, a double-exception PC register, the exception-cause register and the hardware instruction-breakpoint enable. The execution side still writes the program counter, the status word and the vector base through plain write strobes.

Interrupt levels above one each have their own vector and their own pair of saved registers. A level-one interrupt is not given its own vector. It becomes a general exception: a user exception, a kernel exception or a double exception, depending on the status word. The same request port can also raise a plain user, kernel or double exception directly. All control pins are plain strobes, because no data stream passes through the block. A request is a single-cycle strobe, and nothing ever holds it back.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the following values hold:
  - the program counter is RESET_VEC;
  - the status word is 0x1F when HAS_INTERRUPTS is 1 and 0x10 when it is 0;
  - the vector base is DEF_VECBASE;
  - the breakpoint enable is 0;
  - the stored pending level is 0;
  - the cause register is 0;
  - `taken` is low.
- R2: An interrupt request (`req_kind` = 0) is accepted only when three conditions all hold:
  - the stored pending level is greater than status bits [3:0];
  - the stored pending level is no greater than NLEVEL;
  - `LEVEL_MASK[level] & int_pending & int_enable` is non-zero.
- R3: When an interrupt of level L > 1 is accepted, the following happen on one edge:
  - the saved-PC register for L receives the old PC;
  - the saved-status register for L receives the old status word;
  - status bits [3:0] become L and status bit 4 (exception mode) becomes 1, with all other bits kept;
  - the PC becomes the vector for L. By default, that vector is the base plus 0x180 plus (L-2)·0x40.
- R4: When a level-1 interrupt is accepted with status bit 4 clear, the following happen:
  - the level-1 saved-PC register receives the old PC;
  - the cause register receives 4;
  - status bit 4 is set;
  - the PC goes to the user vector (base+0x340) when status bit 5 is 1, and to the kernel vector (base+0x300) when it is 0.
- R5: When a level-1 interrupt is accepted with status bit 4 set, a double exception is raised:
  - the PC goes to the double vector (base+0x3C0) and the cause register receives 4;
  - the old PC goes to the double-exception PC register when HAS_DEPC is 1, and to the level-1 saved-PC register otherwise;
  - the register that is not chosen keeps its value.
- R6: When RELOCATABLE is 1, every taken vector equals its default address minus DEF_VECBASE plus the current vector-base register. The reset vector is never relocated.
- R7: A request with `req_kind` 1 (user), 2 (kernel) or 3 (double) always takes effect. The PC moves to that exception vector, `taken` pulses, and the status word is left unchanged.
- R8: `taken` is high for exactly the one cycle after each accepted request. All of that request's register updates are visible in that same cycle.
- R9: When a request does not qualify, the PC, the status word, the cause register and every saved register keep their values, and `taken` stays low.
- R10: Levels above NLEVEL are never accepted, even when their mask bits are pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle dispatch request strobe |
| req_kind | input | 2 | 0 interrupt, 1 user, 2 kernel, 3 double exception |
| pend_wr_en | input | 1 | Load the stored pending level |
| pend_level_in | input | 3 | New pending level |
| int_pending | input | NIRQ | Pending interrupt bitmap |
| int_enable | input | NIRQ | Enabled interrupt bitmap |
| pc_wr_en | input | 1 | Execution-side PC write |
| pc_wdata | input | 32 | PC write value |
| ps_wr_en | input | 1 | Execution-side status write |
| ps_wdata | input | 32 | Status write value |
| vecbase_wr_en | input | 1 | Vector-base write |
| vecbase_wdata | input | 32 | Vector-base write value |
| ibrk_wr_en | input | 1 | Breakpoint-enable write |
| ibrk_wdata | input | NIBRK | Breakpoint-enable write value |
| rd_level | input | 3 | Selects which banked saved register is shown |
| pc | output | 32 | Current program counter |
| ps | output | 32 | Current status word |
| exc_cause | output | 8 | Exception-cause register |
| taken | output | 1 | One-cycle pulse after an accepted request |
| epc_rd | output | 32 | Saved PC for level `rd_level` |
| eps_rd | output | 32 | Saved status for level `rd_level` (levels 2 and up) |
| depc | output | 32 | Double-exception PC register |
| vecbase | output | 32 | Vector-base register |
| ibrk_en | output | NIBRK | Breakpoint enable |
| pend_level | output | 3 | Stored pending level |

## Verification
The double exception is the hardest path to reach from the ports. It needs a level-one interrupt to arrive while exception mode is already set. After reset the status word blocks every level, so the bench first writes a status word with exception mode set and an interrupt level of zero. It then raises level one. This also shows that the level-1 saved-PC register keeps the value left there by an earlier user-mode dispatch. The relocation case is reached by rewriting the vector base between two dispatches. The bench then compares the new targets against addresses it computes itself.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  typedef enum logic [1:0] {
    REQ_IRQ    = 2'd0,
    REQ_USER   = 2'd1,
    REQ_KERNEL = 2'd2,
    REQ_DOUBLE = 2'd3
  } req_kind_e;

  localparam int MAX_LEVELS = 7;
  localparam int LVL_W      = 3;
  localparam int PS_EXCM    = 4;
  localparam int PS_UM      = 5;
  localparam logic [7:0] CAUSE_LEVEL1 = 8'd4;
endpackage

// File: rtl/irqd_qualify.sv
module irqd_qualify
  import irq_dispatch_pkg::*;
#(
  parameter int NLEVEL = 6,
  parameter int NIRQ   = 8,
  parameter logic [MAX_LEVELS:0][NIRQ-1:0] LEVEL_MASK = '0
) (
  input  logic [LVL_W-1:0] level,
  input  logic [3:0]       cur_level,
  input  logic [NIRQ-1:0]  pending,
  input  logic [NIRQ-1:0]  enable,
  output logic             ok
);
  logic above_cur, in_range, has_src;

  always_comb begin
    above_cur = {1'b0, level} > cur_level;
    in_range  = int'(level) <= NLEVEL;
    has_src   = |(LEVEL_MASK[level] & pending & enable);
    ok        = above_cur && in_range && has_src;
  end
endmodule

// File: rtl/irqd_vecgen.sv
module irqd_vecgen
  import irq_dispatch_pkg::*;
#(
  parameter bit          RELOCATABLE = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'hD000_0000,
  parameter logic [31:0] KERNEL_OFF  = 32'h300,
  parameter logic [31:0] USER_OFF    = 32'h340,
  parameter logic [31:0] DOUBLE_OFF  = 32'h3C0,
  parameter logic [31:0] LVL_OFF     = 32'h180,
  parameter logic [31:0] LVL_STEP    = 32'h40
) (
  input  logic             use_level,
  input  logic [LVL_W-1:0] level,
  input  req_kind_e        kind,
  input  logic [31:0]      vecbase,
  output logic [31:0]      vector
);
  logic [31:0] def_vec;

  always_comb begin
    if (use_level) begin
      def_vec = DEF_VECBASE + LVL_OFF + (32'(level) - 32'd2) * LVL_STEP;
    end else begin
      unique case (kind)
        REQ_USER:   def_vec = DEF_VECBASE + USER_OFF;
        REQ_DOUBLE: def_vec = DEF_VECBASE + DOUBLE_OFF;
        default:    def_vec = DEF_VECBASE + KERNEL_OFF;
      endcase
    end
  end

  generate
    if (RELOCATABLE) begin : g_reloc
      assign vector = def_vec - DEF_VECBASE + vecbase;
    end else begin : g_fixed
      assign vector = def_vec;
    end
  endgenerate
endmodule

// File: rtl/irqd_bank.sv
module irqd_bank
  import irq_dispatch_pkg::*;
#(
  parameter int NLEVEL   = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             epc_we,
  input  logic             eps_we,
  input  logic             depc_we,
  input  logic [LVL_W-1:0] wr_level,
  input  logic [31:0]      pc_in,
  input  logic [31:0]      ps_in,
  input  logic [LVL_W-1:0] rd_level,
  output logic [31:0]      epc_rd,
  output logic [31:0]      eps_rd,
  output logic [31:0]      depc
);
  logic [31:0] epc_q [1:NLEVEL];
  logic [31:0] eps_q [2:NLEVEL];

  generate
    for (genvar g = 1; g <= NLEVEL; g++) begin : g_epc
      always_ff @(posedge clk) begin
        if (!rst_n) epc_q[g] <= '0;
        else if (epc_we && wr_level == LVL_W'(g)) epc_q[g] <= pc_in;
      end
    end
    for (genvar g = 2; g <= NLEVEL; g++) begin : g_eps
      always_ff @(posedge clk) begin
        if (!rst_n) eps_q[g] <= '0;
        else if (eps_we && wr_level == LVL_W'(g)) eps_q[g] <= ps_in;
      end
    end
    if (HAS_DEPC) begin : g_depc
      logic [31:0] depc_q;
      always_ff @(posedge clk) begin
        if (!rst_n) depc_q <= '0;
        else if (depc_we) depc_q <= pc_in;
      end
      assign depc = depc_q;
    end else begin : g_no_depc
      assign depc = '0;
    end
  endgenerate

  always_comb begin
    epc_rd = '0;
    eps_rd = '0;
    for (int l = 1; l <= NLEVEL; l++)
      if (rd_level == LVL_W'(l)) epc_rd = epc_q[l];
    for (int l = 2; l <= NLEVEL; l++)
      if (rd_level == LVL_W'(l)) eps_rd = eps_q[l];
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int          NLEVEL         = 6,
  parameter int          NIRQ           = 8,
  parameter int          NIBRK          = 2,
  parameter bit          HAS_INTERRUPTS = 1'b1,
  parameter bit          HAS_DEPC       = 1'b1,
  parameter bit          RELOCATABLE    = 1'b1,
  parameter logic [31:0] RESET_VEC      = 32'hFE00_0000,
  parameter logic [31:0] DEF_VECBASE    = 32'hD000_0000,
  parameter logic [MAX_LEVELS:0][NIRQ-1:0] LEVEL_MASK = 64'h8040_2010_0804_0300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             pend_wr_en,
  input  logic [2:0]       pend_level_in,
  input  logic [NIRQ-1:0]  int_pending,
  input  logic [NIRQ-1:0]  int_enable,
  input  logic             pc_wr_en,
  input  logic [31:0]      pc_wdata,
  input  logic             ps_wr_en,
  input  logic [31:0]      ps_wdata,
  input  logic             vecbase_wr_en,
  input  logic [31:0]      vecbase_wdata,
  input  logic             ibrk_wr_en,
  input  logic [NIBRK-1:0] ibrk_wdata,
  input  logic [2:0]       rd_level,
  output logic [31:0]      pc,
  output logic [31:0]      ps,
  output logic [7:0]       exc_cause,
  output logic             taken,
  output logic [31:0]      epc_rd,
  output logic [31:0]      eps_rd,
  output logic [31:0]      depc,
  output logic [31:0]      vecbase,
  output logic [NIBRK-1:0] ibrk_en,
  output logic [2:0]       pend_level
);
  localparam logic [31:0] PS_RESET = HAS_INTERRUPTS ? 32'h1F : 32'h10;

  logic [31:0]      pc_q, ps_q, vecbase_q;
  logic [7:0]       cause_q;
  logic             taken_q;
  logic [NIBRK-1:0] ibrk_q;
  logic [LVL_W-1:0] pend_q;

  req_kind_e        kind;
  logic             qual_ok, irq_take, exc_take, take, high_lvl, in_excm, use_level;
  req_kind_e        vec_kind;
  logic [31:0]      target;
  logic             epc_we, eps_we, depc_we;
  logic [LVL_W-1:0] bank_lvl;

  assign kind = req_kind_e'(req_kind);

  irqd_qualify #(.NLEVEL(NLEVEL), .NIRQ(NIRQ), .LEVEL_MASK(LEVEL_MASK)) u_qual (
    .level(pend_q), .cur_level(ps_q[3:0]), .pending(int_pending),
    .enable(int_enable), .ok(qual_ok)
  );

  always_comb begin
    high_lvl  = pend_q > LVL_W'(1);
    in_excm   = ps_q[PS_EXCM];
    irq_take  = req_valid && kind == REQ_IRQ && qual_ok;
    exc_take  = req_valid && kind != REQ_IRQ;
    take      = irq_take || exc_take;
    use_level = irq_take && high_lvl;
    if (!irq_take)     vec_kind = kind;
    else if (in_excm)  vec_kind = REQ_DOUBLE;
    else if (ps_q[PS_UM]) vec_kind = REQ_USER;
    else               vec_kind = REQ_KERNEL;
    eps_we   = use_level;
    epc_we   = irq_take && (high_lvl || !in_excm || !HAS_DEPC);
    depc_we  = irq_take && !high_lvl && in_excm && HAS_DEPC;
    bank_lvl = high_lvl ? pend_q : LVL_W'(1);
  end

  irqd_vecgen #(.RELOCATABLE(RELOCATABLE), .DEF_VECBASE(DEF_VECBASE)) u_vec (
    .use_level(use_level), .level(pend_q), .kind(vec_kind),
    .vecbase(vecbase_q), .vector(target)
  );

  irqd_bank #(.NLEVEL(NLEVEL), .HAS_DEPC(HAS_DEPC)) u_bank (
    .clk(clk), .rst_n(rst_n), .epc_we(epc_we), .eps_we(eps_we),
    .depc_we(depc_we), .wr_level(bank_lvl), .pc_in(pc_q), .ps_in(ps_q),
    .rd_level(rd_level), .epc_rd(epc_rd), .eps_rd(eps_rd), .depc(depc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= RESET_VEC;
      ps_q      <= PS_RESET;
      vecbase_q <= DEF_VECBASE;
      cause_q   <= '0;
      taken_q   <= 1'b0;
      ibrk_q    <= '0;
      pend_q    <= '0;
    end else begin
      taken_q <= take;
      if (take) begin
        pc_q <= target;
      end else if (pc_wr_en) begin
        pc_q <= pc_wdata;
      end
      if (use_level) begin
        ps_q <= {ps_q[31:5], 1'b1, 1'b0, pend_q};
      end else if (irq_take) begin
        ps_q    <= ps_q | (32'd1 << PS_EXCM);
      end else if (ps_wr_en && !take) begin
        ps_q <= ps_wdata;
      end
      if (irq_take && !high_lvl) cause_q <= CAUSE_LEVEL1;
      if (vecbase_wr_en) vecbase_q <= vecbase_wdata;
      if (ibrk_wr_en)    ibrk_q    <= ibrk_wdata;
      if (pend_wr_en)    pend_q    <= pend_level_in;
    end
  end

  assign pc         = pc_q;
  assign ps         = ps_q;
  assign exc_cause  = cause_q;
  assign taken      = taken_q;
  assign vecbase    = vecbase_q;
  assign ibrk_en    = ibrk_q;
  assign pend_level = pend_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int NLEVEL = 6,
  parameter int NIRQ   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic            ps_wr_en,
  input logic [NIRQ-1:0] int_pending,
  input logic [NIRQ-1:0] int_enable,
  input logic [31:0]     ps,
  input logic [2:0]      pend_level,
  input logic            taken
);
  // R8
  taken_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !taken);

  // R3
  irq_sets_excm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |=> (!taken || ps[4]));

  // R9
  ps_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !ps_wr_en) |=> $stable(ps));

  // R10
  over_nlevel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && int'(pend_level) > NLEVEL) |=> !taken);

  // R2
  below_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && {1'b0, pend_level} <= ps[3:0]) |=> !taken);

  // R2
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && (int_pending & int_enable) == '0) |=> !taken);
endmodule

bind irq_dispatch irq_dispatch_chk #(.NLEVEL(NLEVEL), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .ps_wr_en(ps_wr_en), .int_pending(int_pending), .int_enable(int_enable),
  .ps(ps), .pend_level(pend_level), .taken(taken)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0;
  logic [1:0]  req_kind = 0;
  logic        pend_wr_en = 0;
  logic [2:0]  pend_level_in = 0;
  logic [7:0]  int_pending = 0, int_enable = 0;
  logic        pc_wr_en = 0, ps_wr_en = 0, vecbase_wr_en = 0, ibrk_wr_en = 0;
  logic [31:0] pc_wdata = 0, ps_wdata = 0, vecbase_wdata = 0;
  logic [1:0]  ibrk_wdata = 0;
  logic [2:0]  rd_level = 0;
  logic [31:0] pc, ps, epc_rd, eps_rd, depc, vecbase;
  logic [7:0]  exc_cause;
  logic        taken;
  logic [1:0]  ibrk_en;
  logic [2:0]  pend_level;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] base = 32'hD000_0000;

  irq_dispatch dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ps(logic [31:0] v);
    @(negedge clk); ps_wr_en = 1; ps_wdata = v;
    @(negedge clk); ps_wr_en = 0;
  endtask

  task automatic set_pc(logic [31:0] v);
    @(negedge clk); pc_wr_en = 1; pc_wdata = v;
    @(negedge clk); pc_wr_en = 0;
  endtask

  task automatic set_lvl(logic [2:0] l, logic [7:0] p, logic [7:0] e);
    @(negedge clk); pend_wr_en = 1; pend_level_in = l;
    int_pending = p; int_enable = e;
    @(negedge clk); pend_wr_en = 0;
  endtask

  // request is held for one cycle; on return the outputs of that edge are visible
  task automatic fire(logic [1:0] k);
    @(negedge clk); req_valid = 1; req_kind = k;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 pc", pc, 32'hFE00_0000);
    chk("R1 ps", ps, 32'h1F);
    chk("R1 vecbase", vecbase, base);
    chk("R1 ibrk", {30'd0, ibrk_en}, 0);
    chk("R1 pend", {29'd0, pend_level}, 0);
    chk("R1 cause", {24'd0, exc_cause}, 0);
    chk("R1 taken", {31'd0, taken}, 0);
  endtask

  task automatic t_blocked_at_reset_ps;
    set_lvl(3'd2, 8'h04, 8'h04);
    fire(2'd0);
    chk("R9 taken", {31'd0, taken}, 0);
    chk("R9 pc", pc, 32'hFE00_0000);
    rd_level = 3'd2; #1;
    chk("R9 epc2", epc_rd, 0);
  endtask

  task automatic t_high_level;
    set_ps(32'h0); set_pc(32'h1000);
    set_lvl(3'd3, 8'h08, 8'h08);
    fire(2'd0);
    chk("R8 taken", {31'd0, taken}, 1);
    chk("R3 pc", pc, base + 32'h1C0);
    chk("R3 ps", ps, 32'h13);
    rd_level = 3'd3; #1;
    chk("R3 epc3", epc_rd, 32'h1000);
    chk("R3 eps3", eps_rd, 32'h0);
    @(negedge clk);
    chk("R8 pulse ends", {31'd0, taken}, 0);
  endtask

  task automatic t_not_qualified;
    set_ps(32'h3); set_pc(32'h1100);
    set_lvl(3'd3, 8'h08, 8'h08);
    fire(2'd0);
    chk("R2 equal level", {31'd0, taken}, 0);
    set_ps(32'h0);
    set_lvl(3'd2, 8'h08, 8'hFF);
    fire(2'd0);
    chk("R2 wrong mask", {31'd0, taken}, 0);
    set_lvl(3'd2, 8'h04, 8'h00);
    fire(2'd0);
    chk("R2 disabled", {31'd0, taken}, 0);
    set_lvl(3'd7, 8'h80, 8'h80);
    fire(2'd0);
    chk("R10 above nlevel", {31'd0, taken}, 0);
    chk("R9 pc kept", pc, 32'h1100);
    chk("R9 ps kept", ps, 32'h0);
  endtask

  task automatic t_level1;
    set_ps(32'h0); set_pc(32'h2000);
    set_lvl(3'd1, 8'h01, 8'h01);
    fire(2'd0);
    chk("R4 kernel pc", pc, base + 32'h300);
    chk("R4 kernel ps", ps, 32'h10);
    chk("R4 cause", {24'd0, exc_cause}, 4);
    rd_level = 3'd1; #1;
    chk("R4 epc1", epc_rd, 32'h2000);
    set_ps(32'h20); set_pc(32'h2100);
    fire(2'd0);
    chk("R4 user pc", pc, base + 32'h340);
    chk("R4 user ps", ps, 32'h30);
    set_ps(32'h10); set_pc(32'h2200);
    fire(2'd0);
    chk("R5 double pc", pc, base + 32'h3C0);
    chk("R5 depc", depc, 32'h2200);
    rd_level = 3'd1; #1;
    chk("R5 epc1 kept", epc_rd, 32'h2100);
    chk("R5 ps", ps, 32'h10);
  endtask

  task automatic t_reloc_and_exc;
    @(negedge clk); vecbase_wr_en = 1; vecbase_wdata = 32'h4000_0000;
    @(negedge clk); vecbase_wr_en = 0;
    set_ps(32'h0); set_pc(32'h3000);
    set_lvl(3'd2, 8'h04, 8'h04);
    fire(2'd0);
    chk("R6 reloc pc", pc, 32'h4000_0180);
    set_ps(32'h25);
    fire(2'd2);
    chk("R7 kernel exc pc", pc, 32'h4000_0300);
    chk("R7 ps unchanged", ps, 32'h25);
    chk("R7 taken", {31'd0, taken}, 1);
    fire(2'd1);
    chk("R7 user exc pc", pc, 32'h4000_0340);
    @(negedge clk);
    chk("R8 single pulse", {31'd0, taken}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset;
    t_blocked_at_reset_ps;
    t_high_level;
    t_not_qualified;
    t_level1;
    t_reloc_and_exc;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule